// File: doc/BRIEF.md
# MII Receive Output Sequencer

This block drives the receive half of a media-independent interface from a PHY's internal receive datapath. The datapath supplies a decoded nibble, start and end strobes, a clock-recovered level, a per-nibble symbol error flag, a collision level, a link-good flag and a speed select. The block turns these into the MAC-facing signals `rxd`, `rx_dv`, `crs`, `rx_er` and `col`. It steps carrier and data-valid through four states:

- `ST_IDLE`: no carrier.
- `ST_CARRIER`: carrier is up and data is not yet valid.
- `ST_DATA`: nibbles are being presented.
- `ST_END`: the one receive-clock period after the end strobe.

It also applies the rules that differ between 100 Mbps and 10 Mbps operation.

All logic runs on one fast clock `clk`. Each receive clock period is represented by one cycle of the enable `rx_tick`, and outputs change only on that cycle. `rx_tick` is taken from one of two enable inputs: `tx_ce`, the transmit clock, or `rec_ce`, the recovered clock. The source register changes only on a fast cycle where neither enable is high, so a receive clock period is never shortened.

The transitions are:

- `ST_IDLE` to `ST_CARRIER` on a tick with `sop`.
- `ST_CARRIER` to `ST_DATA` on a tick once the recovered source is selected. At 10 Mbps this also needs lock to have been seen.
- `ST_CARRIER` or `ST_DATA` to `ST_END` on a tick with `eop`.
- `ST_END` to `ST_IDLE` on the next tick.
- Any state to `ST_IDLE` on the first fast cycle with `link_ok` low.

Top module: `mii_rx_seq`

## Requirements
- R1: While `rst_n` is low, `rxd` is 0, `rx_dv`, `crs`, `rx_er` and `col` are 0, and `rxclk_src` is 0, where 0 means the transmit clock.
- R2: A tick in `ST_IDLE` with `sop` high and the link good raises `crs` on that tick, with `rx_dv` low and `rxd` equal to 0.
- R3: At 100 Mbps, the tick after the carrier tick enters `ST_DATA`: `rx_dv` rises and `rxd` shows the nibble sampled on that tick. Each later tick in `ST_DATA` updates `rxd` to the nibble sampled on that tick.
- R4: At 100 Mbps, `rx_er` is high for exactly the one tick period whose `rxd` value was sampled together with `sym_err` high, and low on the next tick if that nibble is clean.
- R5: At 10 Mbps, `rx_er` stays low even when `sym_err` is high, while `rxd` still carries the nibble.
- R6: At 10 Mbps, while no packet has locked, `rxclk_src` is 0 and `rx_tick` equals `tx_ce`.
- R7: At 10 Mbps, `rx_dv` stays low until `clk_locked` has been sampled on a tick. `rxclk_src` then becomes 1 on a fast cycle with both `tx_ce` and `rec_ce` low, and `rx_dv` rises on the first `rec_ce` tick after that.
- R8: A tick with `eop` in `ST_CARRIER` or `ST_DATA` drops `crs` and `rx_dv` and sets `rxd` to 0 on that tick. One tick later the state returns to `ST_IDLE`, and at 10 Mbps `rxclk_src` falls back to 0.
- R9: The fast cycle after `link_ok` falls has `crs`, `rx_dv` and `rx_er` low and `rxd` equal to 0. While `link_ok` stays low, `sop` is ignored.
- R10: `col` equals `coll` delayed by one fast cycle, in every state and at both speeds.
- R11: At 100 Mbps, `rxclk_src` is 1 (the recovered clock) from the first quiet fast cycle after reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1 for 100 Mbps, 0 for 10 Mbps |
| link_ok | input | 1 | Link good; low means link failed |
| tx_ce | input | 1 | Transmit clock enable, one cycle per period |
| rec_ce | input | 1 | Recovered clock enable, one cycle per period |
| sop | input | 1 | Start of packet, sampled on a tick |
| eop | input | 1 | End of packet, sampled on a tick |
| clk_locked | input | 1 | Clock recovery complete, sampled on a tick |
| sym_err | input | 1 | Error flag for the nibble sampled on this tick |
| coll | input | 1 | Collision condition |
| nib_in | input | NIB_W | Decoded receive nibble |
| rx_tick | output | 1 | Selected receive clock enable |
| rxclk_src | output | 1 | Receive clock source: 0 transmit, 1 recovered |
| rxd | output | NIB_W | Receive data to MAC |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |
| rx_er | output | 1 | Receive error |
| col | output | 1 | Collision |

## Verification
A wrong state shows up at `crs` and `rx_dv` on the very next receive tick. Stuck in `ST_CARRIER`, data-valid never rises. Stuck in `ST_DATA`, carrier survives the end strobe.

A stale lock flag shows up as `rxclk_src` staying 1 after a 10 Mbps packet. It is visible within one quiet fast cycle after the state returns to `ST_IDLE`.

A missed link drop is visible one fast cycle after `link_ok` falls, without waiting for any tick.

// File: rtl/mii_rx_seq_pkg.sv
package mii_rx_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CARRIER = 2'd1,
        ST_DATA    = 2'd2,
        ST_END     = 2'd3
    } rx_state_e;
endpackage

// File: rtl/mii_rx_clksel.sv
// Receive clock enable selection; the source flips only in a quiet cycle.
module mii_rx_clksel (
    input  logic clk,
    input  logic rst_n,
    input  logic want_rec,
    input  logic tx_ce,
    input  logic rec_ce,
    output logic src_rec,
    output logic rx_tick
);
    logic quiet;

    assign quiet = ~tx_ce & ~rec_ce;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_rec <= 1'b0;
        end else if (quiet) begin
            src_rec <= want_rec;
        end
    end

    assign rx_tick = src_rec ? rec_ce : tx_ce;
endmodule

// File: rtl/mii_rx_fsm.sv
// Carrier and data-valid sequencing, output registers.
module mii_rx_fsm
    import mii_rx_seq_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_tick,
    input  logic             speed_100,
    input  logic             link_ok,
    input  logic             src_rec,
    input  logic             sop,
    input  logic             eop,
    input  logic             clk_locked,
    input  logic             sym_err,
    input  logic             coll,
    input  logic [NIB_W-1:0] nib_in,
    output logic             want_rec,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             crs,
    output logic             rx_er,
    output logic             col
);
    localparam logic [NIB_W-1:0] NIB_ZERO = '0;

    rx_state_e state_q, state_d;
    logic      lock_q;
    logic      data_ok;

    assign data_ok  = src_rec & (speed_100 | lock_q);
    assign want_rec = speed_100 | lock_q;

    always_comb begin
        state_d = state_q;
        if (!link_ok) begin
            state_d = ST_IDLE;
        end else if (rx_tick) begin
            unique case (state_q)
                ST_IDLE:    if (sop) state_d = ST_CARRIER;
                ST_CARRIER: begin
                    if (eop)          state_d = ST_END;
                    else if (data_ok) state_d = ST_DATA;
                end
                ST_DATA:    if (eop) state_d = ST_END;
                ST_END:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_IDLE) begin
                lock_q <= 1'b0;
            end else if (rx_tick && state_q == ST_CARRIER && clk_locked) begin
                lock_q <= 1'b1;
            end
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd   <= NIB_ZERO;
            rx_dv <= 1'b0;
            crs   <= 1'b0;
            rx_er <= 1'b0;
            col   <= 1'b0;
        end else begin
            col <= coll;
            if (!link_ok) begin
                rxd   <= NIB_ZERO;
                rx_dv <= 1'b0;
                crs   <= 1'b0;
                rx_er <= 1'b0;
            end else if (rx_tick) begin
                crs   <= (state_d == ST_CARRIER) || (state_d == ST_DATA);
                rx_dv <= (state_d == ST_DATA);
                rxd   <= (state_d == ST_DATA) ? nib_in : NIB_ZERO;
                rx_er <= (state_d == ST_DATA) && sym_err && speed_100;
            end
        end
    end
endmodule

// File: rtl/mii_rx_seq.sv
module mii_rx_seq #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_100,
    input  logic             link_ok,
    input  logic             tx_ce,
    input  logic             rec_ce,
    input  logic             sop,
    input  logic             eop,
    input  logic             clk_locked,
    input  logic             sym_err,
    input  logic             coll,
    input  logic [NIB_W-1:0] nib_in,
    output logic             rx_tick,
    output logic             rxclk_src,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             crs,
    output logic             rx_er,
    output logic             col
);
    logic want_rec;

    mii_rx_clksel u_clksel (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_rec (want_rec),
        .tx_ce    (tx_ce),
        .rec_ce   (rec_ce),
        .src_rec  (rxclk_src),
        .rx_tick  (rx_tick)
    );

    mii_rx_fsm #(.NIB_W(NIB_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_tick    (rx_tick),
        .speed_100  (speed_100),
        .link_ok    (link_ok),
        .src_rec    (rxclk_src),
        .sop        (sop),
        .eop        (eop),
        .clk_locked (clk_locked),
        .sym_err    (sym_err),
        .coll       (coll),
        .nib_in     (nib_in),
        .want_rec   (want_rec),
        .rxd        (rxd),
        .rx_dv      (rx_dv),
        .crs        (crs),
        .rx_er      (rx_er),
        .col        (col)
    );
endmodule

// File: rtl/mii_rx_seq_chk.sv
module mii_rx_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic speed_100,
    input logic link_ok,
    input logic tx_ce,
    input logic rec_ce,
    input logic coll,
    input logic rx_tick,
    input logic rxclk_src,
    input logic rx_dv,
    input logic crs,
    input logic rx_er,
    input logic col
);
    AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok |=> (!crs && !rx_dv && !rx_er)); // R9

    AST_ER_10M: assert property (@(posedge clk) disable iff (!rst_n)
        (!speed_100 && rx_tick) |=> !rx_er); // R5

    AST_DV_HAS_CRS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> crs); // R3

    AST_ER_HAS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> rx_dv); // R4

    AST_COL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (col == $past(coll))); // R10

    AST_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rxclk_src != $past(rxclk_src)) |-> (!$past(tx_ce) && !$past(rec_ce))); // R7

    AST_DV_10M_REC: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && !speed_100) |-> rxclk_src); // R7
endmodule

bind mii_rx_seq mii_rx_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_100 (speed_100),
    .link_ok   (link_ok),
    .tx_ce     (tx_ce),
    .rec_ce    (rec_ce),
    .coll      (coll),
    .rx_tick   (rx_tick),
    .rxclk_src (rxclk_src),
    .rx_dv     (rx_dv),
    .crs       (crs),
    .rx_er     (rx_er),
    .col       (col)
);

// File: tb/mii_rx_seq_test.sv
`timescale 1ns/1ps
module mii_rx_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_100 = 1'b1;
    logic       link_ok = 1'b1;
    logic       tx_ce = 1'b0;
    logic       rec_ce = 1'b0;
    logic       sop = 1'b0;
    logic       eop = 1'b0;
    logic       clk_locked = 1'b0;
    logic       sym_err = 1'b0;
    logic       coll = 1'b0;
    logic [3:0] nib_in = 4'h0;
    logic       rx_tick, rxclk_src, rx_dv, crs, rx_er, col;
    logic [3:0] rxd;

    int tests = 0;
    int fails = 0;
    int cnt = 0;

    always #2 clk = ~clk;

    // enable generator: period of 10 fast cycles, transmit at 0, recovered at 5
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cnt = (cnt == 9) ? 0 : cnt + 1;
            tx_ce = (cnt == 0);
            rec_ce = (cnt == 5);
        end
    end

    mii_rx_seq uut (
        .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .link_ok(link_ok),
        .tx_ce(tx_ce), .rec_ce(rec_ce), .sop(sop), .eop(eop),
        .clk_locked(clk_locked), .sym_err(sym_err), .coll(coll), .nib_in(nib_in),
        .rx_tick(rx_tick), .rxclk_src(rxclk_src), .rxd(rxd), .rx_dv(rx_dv),
        .crs(crs), .rx_er(rx_er), .col(col)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive inputs for one receive tick; returns at the negedge after that tick
    task automatic step(input logic s, input logic e, input logic lk,
                        input logic er, input logic [3:0] n);
        @(negedge clk);
        sop = s; eop = e; clk_locked = lk; sym_err = er; nib_in = n;
        while (!rx_tick) @(negedge clk);
        @(negedge clk);
        sop = 1'b0; eop = 1'b0; clk_locked = 1'b0; sym_err = 1'b0; nib_in = 4'h0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rxd", {4'h0, rxd}, 8'h00);
        check("R1 flags", {4'h0, rx_dv, crs, rx_er, col}, 8'h00);
        check("R1 rxclk_src", {7'h0, rxclk_src}, 8'h00);
    endtask

    task automatic t_fast_packet();
        speed_100 = 1'b1;
        repeat (12) @(negedge clk);
        check("R11 src recovered", {7'h0, rxclk_src}, 8'h01);
        step(1, 0, 0, 0, 4'h0);
        check("R2 crs/dv/rxd", {2'b0, crs, rx_dv, rxd}, {2'b0, 1'b1, 1'b0, 4'h0});
        step(0, 0, 0, 0, 4'hA);
        check("R3 first nibble", {2'b0, crs, rx_dv, rxd}, {2'b0, 1'b1, 1'b1, 4'hA});
        step(0, 0, 0, 0, 4'h5);
        check("R3 next nibble", {4'h0, rxd}, 8'h05);
        step(0, 0, 0, 1, 4'h3);
        check("R4 er on errored nibble", {3'b0, rx_er, rxd}, {3'b0, 1'b1, 4'h3});
        step(0, 0, 0, 0, 4'h7);
        check("R4 er clears", {3'b0, rx_er, rxd}, {3'b0, 1'b0, 4'h7});
        step(0, 1, 0, 0, 4'hF);
        check("R8 eop drop", {2'b0, crs, rx_dv, rxd}, 8'h00);
        step(0, 0, 0, 0, 4'h0);
    endtask

    task automatic t_slow_packet();
        speed_100 = 1'b0;
        repeat (12) @(negedge clk);
        check("R6 idle src transmit", {7'h0, rxclk_src}, 8'h00);
        for (int i = 0; i < 10; i++) begin
            check("R6 tick follows tx_ce", {7'h0, rx_tick}, {7'h0, tx_ce});
            @(negedge clk);
        end
        step(1, 0, 0, 0, 4'h0);
        check("R2 crs at 10M", {6'b0, crs, rx_dv}, 8'h02);
        step(0, 0, 0, 0, 4'h4);
        check("R7 no dv before lock", {6'b0, crs, rx_dv}, 8'h02);
        step(0, 0, 1, 0, 4'h4);
        check("R7 no dv on lock tick", {7'h0, rx_dv}, 8'h00);
        step(0, 0, 0, 0, 4'h9);
        check("R7 dv after switch", {2'b0, rxclk_src, rx_dv, rxd}, {2'b0, 1'b1, 1'b1, 4'h9});
        step(0, 0, 0, 1, 4'hC);
        check("R5 er held low", {3'b0, rx_er, rxd}, {3'b0, 1'b0, 4'hC});
        step(0, 1, 0, 0, 4'h0);
        check("R8 eop drop 10M", {2'b0, crs, rx_dv, rxd}, 8'h00);
        step(0, 0, 0, 0, 4'h0);
        repeat (3) @(negedge clk);
        check("R8 src back to transmit", {7'h0, rxclk_src}, 8'h00);
    endtask

    task automatic t_link_drop();
        speed_100 = 1'b1;
        repeat (12) @(negedge clk);
        step(1, 0, 0, 0, 4'h0);
        step(0, 0, 0, 0, 4'h6);
        check("R9 in data", {6'b0, crs, rx_dv}, 8'h03);
        link_ok = 1'b0;
        @(negedge clk);
        check("R9 drop", {2'b0, crs, rx_dv, rxd}, 8'h00);
        step(1, 0, 0, 0, 4'h0);
        check("R9 sop ignored", {6'b0, crs, rx_dv}, 8'h00);
        link_ok = 1'b1;
        step(0, 0, 0, 0, 4'h2);
        check("R9 idle after restore", {6'b0, crs, rx_dv}, 8'h00);
    endtask

    task automatic t_collision();
        @(negedge clk);
        coll = 1'b1;
        @(negedge clk);
        check("R10 col high", {7'h0, col}, 8'h01);
        coll = 1'b0;
        @(negedge clk);
        check("R10 col low", {7'h0, col}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_fast_packet();
        t_slow_packet();
        t_link_drop();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule